// File: doc/BRIEF.md
# Address-Generation Interlock Controller

This block decides, cycle by cycle, whether the instruction sitting in decode may move into the address-generation stage of a single-issue, six-stage in-order pipeline. The stages are decode, address generation, cache cycle 1, cache cycle 2, execute and writeback. Addresses are formed in the stage right after decode. A register written by an older instruction and then used as a base or index by a younger one must therefore have been produced several issue slots earlier. How many slots depends on the producer class: load results and load-address results have bypass paths back to address generation, and all other producers do not.

A per-register countdown records how many more advancing cycles must pass before each register may be used for an address. The instruction in decode compares its base and index fields against these counters. While any relevant counter is nonzero, decode is held and a bubble enters address generation. The block also models execute-stage occupancy. When a multi-cycle instruction reaches execute, the whole pipeline freezes until that instruction is done, and the countdowns pause during the freeze. Instruction class, destination and address fields come from the decoder as inputs. A saturating count of stall cycles is provided for observation.

Top module: `agi_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `stall_count` is 0, `ex_busy` is low, and every register counter is clear. An address consumer presented right after reset issues in the same cycle.
- R2: Class encoding on `dec_class`: 0 integer, 1 memory, 2 load, 3 store, 4 load-address, 5 call, 6 two-cycle op, 7 three-cycle op. A producer of class 0, 1, 5, 6 or 7 must issue at least 5 advancing cycles before an address consumer that reads its destination, so a consumer following directly stalls 4 cycles.
- R3: A load (class 2) producer needs an issue distance of 3 cycles. A consumer following directly stalls 2 cycles, and a consumer one idle slot later stalls 1 cycle.
- R4: A load-address (class 4) producer needs an issue distance of 2 cycles. A consumer following directly stalls 1 cycle.
- R5: The index field interlocks exactly like the base field.
- R6: Register 0 in the base or index field never causes a stall, and writing register 0 arms no counter.
- R7: Only classes 1, 2, 3, 4 and 5 are address consumers. An instruction of class 0, 6 or 7 whose fields name a pending register is not stalled by the interlock.
- R8: An instruction entering execute occupies it for 2 cycles (class 6), 3 cycles (class 7), 5 cycles (class 5), or 1 cycle otherwise. `ex_busy` is high for the extra cycles, starting 4 cycles after issue, and during them a valid decode instruction is stalled.
- R9: Register counters advance only in cycles when the pipeline moves. A class 6 producer followed directly by a dependent consumer therefore stalls it 5 cycles.
- R10: `stall_count` increases by one for each cycle with `dec_stall` high and saturates at its all-ones value.
- R11: `dec_issue` and `dec_stall` are never both high, and exactly one of them is high whenever `dec_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction occupies decode |
| dec_class | input | 3 | Decoded instruction class (encoding in R2) |
| dec_dst_we | input | 1 | Instruction writes a general register |
| dec_dst | input | RW (4) | Destination register number |
| dec_base | input | RW (4) | Base register for the address (0 = none) |
| dec_index | input | RW (4) | Index register for the address (0 = none) |
| dec_issue | output | 1 | Decode instruction moves to address generation this cycle |
| dec_stall | output | 1 | Decode instruction is held this cycle |
| ex_busy | output | 1 | Execute is held by a multi-cycle instruction |
| stall_count | output | CNT_W (16) | Saturating count of stall cycles |

## Verification
The hardest case to reach is the overlap of the two hold causes: a multi-cycle producer whose execute freeze lands in the middle of its own address-interlock window. Only then do the paused countdowns matter. The stimulus issues a two-cycle op and presents a dependent store on the very next cycle, so the freeze happens 4 cycles later while the store is still waiting, and the bench expects 5 stall cycles instead of 4. A separate run of back-to-back dependent pairs pushes the narrowed stall counter of the bench instance past its saturation point.

// File: rtl/agi_pkg.sv
// Shared definitions for the address-generation interlock controller.
// Assumes the decoder delivers one of eight classes on a 3-bit field.
package agi_pkg;

    typedef enum logic [2:0] {
        CL_INT   = 3'd0,
        CL_MEM   = 3'd1,
        CL_LOAD  = 3'd2,
        CL_STORE = 3'd3,
        CL_LADDR = 3'd4,
        CL_CALL  = 3'd5,
        CL_OP2   = 3'd6,
        CL_OP3   = 3'd7
    } instr_class_e;

    // True for classes that read base/index registers in address generation.
    function automatic logic forms_address(input instr_class_e c);
        return (c == CL_MEM) || (c == CL_LOAD) || (c == CL_STORE) ||
               (c == CL_LADDR) || (c == CL_CALL);
    endfunction

endpackage

// File: rtl/agi_scoreboard.sv
// Per-register countdown of advancing cycles left before a register may
// feed address generation. Assumes DIST_GEN is the largest distance and
// that the caller never writes register 0.
module agi_scoreboard
    import agi_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int DIST_GEN  = 5,
    parameter int DIST_LOAD = 3,
    parameter int DIST_LA   = 2,
    localparam int RW       = $clog2(NREG),
    localparam int SB_W     = $clog2(DIST_GEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_reg,
    input  instr_class_e  wr_class,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    output logic          busy_a,
    output logic          busy_b
);

    logic [SB_W-1:0] cnt_q [NREG];
    logic [SB_W-1:0] load_val;

    // Select the countdown start for the producing class.
    always_comb begin
        case (wr_class)
            CL_LOAD:  load_val = SB_W'(DIST_LOAD - 1);
            CL_LADDR: load_val = SB_W'(DIST_LA - 1);
            default:  load_val = SB_W'(DIST_GEN - 1);
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        // Arm on issue of a writer, otherwise count down on each advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (wr_en && (wr_reg == RW'(g))) begin
                cnt_q[g] <= load_val;
            end else if (advance && (cnt_q[g] != '0)) begin
                cnt_q[g] <= cnt_q[g] - 1'b1;
            end
        end
    end

    // Report whether the two looked-up registers are still pending.
    always_comb begin
        busy_a = (cnt_q[rd_a] != '0);
        busy_b = (cnt_q[rd_b] != '0);
    end

endmodule

// File: rtl/agi_exec_tracker.sv
// Follows issued instruction classes through address generation and both
// cache cycles, then holds the pipeline while a multi-cycle class sits in
// execute. Assumes every occupancy is at least 1.
module agi_exec_tracker
    import agi_pkg::*;
#(
    parameter int O2_CYC   = 2,
    parameter int O3_CYC   = 3,
    parameter int CALL_CYC = 5,
    parameter int NPRE     = 3,
    localparam int MAXC    = (CALL_CYC > O3_CYC) ? CALL_CYC : O3_CYC,
    localparam int EX_W    = $clog2(MAXC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enter_valid,
    input  instr_class_e enter_class,
    output logic         ex_hold
);

    logic         v_q [NPRE];
    instr_class_e c_q [NPRE];
    logic [EX_W-1:0] ex_cnt_q;
    logic [EX_W-1:0] occ_extra;
    logic            advance;

    assign advance = (ex_cnt_q == '0);
    assign ex_hold = !advance;

    for (genvar s = 0; s < NPRE; s++) begin : g_stage
        // Shift class tags forward whenever execute accepts new work.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[s] <= 1'b0;
                c_q[s] <= CL_INT;
            end else if (advance) begin
                if (s == 0) begin
                    v_q[s] <= enter_valid;
                    c_q[s] <= enter_class;
                end else begin
                    v_q[s] <= v_q[s-1];
                    c_q[s] <= c_q[s-1];
                end
            end
        end
    end

    // Extra execute cycles owed by the instruction about to enter execute.
    always_comb begin
        case (c_q[NPRE-1])
            CL_OP2:  occ_extra = EX_W'(O2_CYC - 1);
            CL_OP3:  occ_extra = EX_W'(O3_CYC - 1);
            CL_CALL: occ_extra = EX_W'(CALL_CYC - 1);
            default: occ_extra = '0;
        endcase
    end

    // Load the busy counter on entry to execute, then drain it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_cnt_q <= '0;
        end else if (advance) begin
            ex_cnt_q <= v_q[NPRE-1] ? occ_extra : '0;
        end else begin
            ex_cnt_q <= ex_cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/agi_stall_counter.sv
// Saturating counter of stalled decode cycles. Assumes CNT_W >= 1.
module agi_stall_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    output logic [CNT_W-1:0] count
);

    // Add one per stall cycle until all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (stall && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/agi_ctrl.sv
// Top of the address-generation interlock controller. Combines the register
// countdowns and the execute tracker into issue/stall decisions for decode.
// Assumes decoded fields are stable while dec_valid is held with dec_stall.
module agi_ctrl
    import agi_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int DIST_GEN  = 5,
    parameter int DIST_LOAD = 3,
    parameter int DIST_LA   = 2,
    parameter int O2_CYC    = 2,
    parameter int O3_CYC    = 3,
    parameter int CALL_CYC  = 5,
    parameter int CNT_W     = 16,
    localparam int RW       = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [2:0]       dec_class,
    input  logic             dec_dst_we,
    input  logic [RW-1:0]    dec_dst,
    input  logic [RW-1:0]    dec_base,
    input  logic [RW-1:0]    dec_index,
    output logic             dec_issue,
    output logic             dec_stall,
    output logic             ex_busy,
    output logic [CNT_W-1:0] stall_count
);

    instr_class_e cls;
    logic         busy_base, busy_index;
    logic         hazard;
    logic         sb_wr;

    assign cls = instr_class_e'(dec_class);

    // Interlock and issue decision for the decode slot.
    always_comb begin
        hazard = dec_valid && forms_address(cls) &&
                 (((dec_base  != '0) && busy_base) ||
                  ((dec_index != '0) && busy_index));
        dec_issue = dec_valid && !hazard && !ex_busy;
        dec_stall = dec_valid && (hazard || ex_busy);
        sb_wr     = dec_issue && dec_dst_we && (dec_dst != '0);
    end

    agi_scoreboard #(
        .NREG      (NREG),
        .DIST_GEN  (DIST_GEN),
        .DIST_LOAD (DIST_LOAD),
        .DIST_LA   (DIST_LA)
    ) sb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (!ex_busy),
        .wr_en    (sb_wr),
        .wr_reg   (dec_dst),
        .wr_class (cls),
        .rd_a     (dec_base),
        .rd_b     (dec_index),
        .busy_a   (busy_base),
        .busy_b   (busy_index)
    );

    agi_exec_tracker #(
        .O2_CYC   (O2_CYC),
        .O3_CYC   (O3_CYC),
        .CALL_CYC (CALL_CYC)
    ) ex_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_valid (dec_issue),
        .enter_class (cls),
        .ex_hold     (ex_busy)
    );

    agi_stall_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stall (dec_stall),
        .count (stall_count)
    );

endmodule

// File: rtl/agi_ctrl_chk.sv
// Property checker for agi_ctrl, attached by bind. Observes ports only.
module agi_ctrl_chk #(
    parameter int RW    = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [2:0]       dec_class,
    input logic             dec_dst_we,
    input logic [RW-1:0]    dec_dst,
    input logic [RW-1:0]    dec_base,
    input logic [RW-1:0]    dec_index,
    input logic             dec_issue,
    input logic             dec_stall,
    input logic             ex_busy,
    input logic [CNT_W-1:0] stall_count
);

    logic addr_user;
    assign addr_user = (dec_class >= 3'd1) && (dec_class <= 3'd5);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (stall_count == '0 && !ex_busy));

    assert_gen_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dec_issue) && $past(dec_dst_we) &&
         ($past(dec_class) == 3'd0) && ($past(dec_dst) != '0) &&
         dec_valid && addr_user && (dec_base == $past(dec_dst))) |-> dec_stall);

    assert_load_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dec_issue) && $past(dec_dst_we) &&
         ($past(dec_class) == 3'd2) && ($past(dec_dst) != '0) &&
         dec_valid && addr_user && (dec_index == $past(dec_dst))) |-> dec_stall);

    assert_reg0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_base == '0 && dec_index == '0 && !ex_busy) |-> dec_issue);

    assert_plain_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !addr_user && !ex_busy) |-> dec_issue);

    assert_exec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ex_busy) |-> (dec_stall && !dec_issue));

    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && stall_count != '1) |=> (stall_count == $past(stall_count) + 1'b1));

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_stall) |=> $stable(stall_count));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_issue && dec_stall) && (dec_valid == (dec_issue || dec_stall)));

endmodule

bind agi_ctrl agi_ctrl_chk #(.RW(RW), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_class   (dec_class),
    .dec_dst_we  (dec_dst_we),
    .dec_dst     (dec_dst),
    .dec_base    (dec_base),
    .dec_index   (dec_index),
    .dec_issue   (dec_issue),
    .dec_stall   (dec_stall),
    .ex_busy     (ex_busy),
    .stall_count (stall_count)
);

// File: tb/agi_ctrl_tb_top.sv
// Self-checking bench for agi_ctrl: a producer/consumer vector table, then
// directed tests for reset, execute occupancy, gaps and saturation.
module agi_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 6;
    localparam int CMAX       = (1 << CW) - 1;
    localparam int NV         = 10;

    // Row: prod class(3) prod dst(4) cons class(3) base(4) index(4) stalls(4) req(4)
    localparam logic [25:0] VEC [NV] = '{
        {3'd0, 4'd3,  3'd2, 4'd3,  4'd0, 4'd4, 4'd2},  // R2 int -> load base
        {3'd1, 4'd5,  3'd1, 4'd0,  4'd5, 4'd4, 4'd5},  // R5 mem -> mem index
        {3'd2, 4'd2,  3'd4, 4'd2,  4'd0, 4'd2, 4'd3},  // R3 load -> laddr
        {3'd4, 4'd7,  3'd5, 4'd7,  4'd0, 4'd1, 4'd4},  // R4 laddr -> call
        {3'd0, 4'd0,  3'd2, 4'd0,  4'd0, 4'd0, 4'd6},  // R6 register 0
        {3'd0, 4'd4,  3'd0, 4'd4,  4'd4, 4'd0, 4'd7},  // R7 int consumer
        {3'd6, 4'd6,  3'd3, 4'd6,  4'd0, 4'd5, 4'd9},  // R9 op2 -> store
        {3'd2, 4'd9,  3'd7, 4'd9,  4'd0, 4'd0, 4'd7},  // R7 op3 consumer
        {3'd0, 4'd1,  3'd2, 4'd8,  4'd1, 4'd4, 4'd5},  // R5 index hit
        {3'd4, 4'd10, 3'd2, 4'd11, 4'd0, 4'd0, 4'd2}   // R2 no dependence
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0;
    logic [2:0]    dec_class = '0;
    logic          dec_dst_we = 1'b0;
    logic [3:0]    dec_dst = '0;
    logic [3:0]    dec_base = '0;
    logic [3:0]    dec_index = '0;
    logic          dec_issue, dec_stall, ex_busy;
    logic [CW-1:0] stall_count;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    agi_ctrl #(.CNT_W(CW)) dut_i (
        .clk (clk), .rst_n (rst_n), .dec_valid (dec_valid), .dec_class (dec_class),
        .dec_dst_we (dec_dst_we), .dec_dst (dec_dst), .dec_base (dec_base),
        .dec_index (dec_index), .dec_issue (dec_issue), .dec_stall (dec_stall),
        .ex_busy (ex_busy), .stall_count (stall_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then wait a quarter period before sampling.
    task automatic drive(input bit v, input int cls, input bit we, input int dst,
                         input int base, input int idx);
        @(negedge clk);
        dec_valid = v; dec_class = 3'(cls); dec_dst_we = we;
        dec_dst = 4'(dst); dec_base = 4'(base); dec_index = 4'(idx);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    function automatic int sat_add(input int a, input int b);
        return (a + b > CMAX) ? CMAX : a + b;
    endfunction

    // Hold a consumer in decode until it issues; return the stall cycles seen.
    task automatic consume(input int cls, input int base, input int idx, output int stalls);
        stalls = 0;
        drive(1, cls, 0, 0, base, idx);
        while (!dec_issue && stalls < 30) begin
            if (!dec_stall) check(0, "R11", 0, 1);
            stalls++;
            drive(1, cls, 0, 0, base, idx);
        end
    endtask

    task automatic busy_profile(input int cls, input int exp_first, input int exp_total,
                                input string req);
        int first = 0;
        int total = 0;
        drive(1, cls, 0, 0, 0, 0);
        check(dec_issue == 1'b1, req, dec_issue, 1);
        for (int j = 1; j <= 12; j++) begin
            drive(0, 0, 0, 0, 0, 0);
            if (ex_busy) begin
                if (first == 0) first = j;
                total++;
            end
        end
        check(first == exp_first, req, first, exp_first);
        check(total == exp_total, req, total, exp_total);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int st;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state and an immediate address consumer.
        drive(1, 2, 0, 0, 5, 3);
        check(stall_count == 0, "R1 count", int'(stall_count), 0);
        check(ex_busy == 1'b0, "R1 busy", ex_busy, 0);
        check(dec_issue == 1'b1, "R1 issue", dec_issue, 1);
        idle(2);

        // Vector table: producer then a directly following consumer.
        for (int k = 0; k < NV; k++) begin
            logic [25:0] v;
            string tag;
            v = VEC[k];
            tag = $sformatf("R%0d row %0d", v[3:0], k);
            drive(1, v[25:23], 1, v[22:19], 0, 0);
            check(dec_issue == 1'b1, tag, dec_issue, 1);
            consume(v[18:16], v[15:12], v[11:8], st);
            check(st == v[7:4], tag, st, v[7:4]);
            exp_cnt = sat_add(exp_cnt, v[7:4]);
            idle(12);
            check(stall_count == exp_cnt, {tag, " R10"}, int'(stall_count), exp_cnt);
        end

        // R3: load producer with one idle slot before the consumer.
        drive(1, 2, 1, 12, 0, 0);
        idle(1);
        consume(1, 12, 0, st);
        check(st == 1, "R3 gap", st, 1);
        exp_cnt = sat_add(exp_cnt, 1);
        idle(12);

        // R8: execute occupancy per class.
        busy_profile(5, 4, 4, "R8 call");
        busy_profile(7, 4, 2, "R8 op3");
        busy_profile(6, 4, 1, "R8 op2");
        busy_profile(3, 0, 0, "R8 store");

        // R1: reset clears a pending register countdown and the counter.
        drive(1, 0, 1, 3, 0, 0);
        @(negedge clk); rst_n = 1'b0; dec_valid = 1'b0;
        idle(2);
        rst_n = 1'b1;
        consume(2, 3, 0, st);
        check(st == 0, "R1 cleared", st, 0);
        check(stall_count == 0, "R1 count", int'(stall_count), 0);
        exp_cnt = 0;

        // R10: saturation through back-to-back dependent pairs.
        for (int p = 0; p < 18; p++) begin
            drive(1, 0, 1, 3, 0, 0);
            consume(2, 3, 0, st);
            exp_cnt = sat_add(exp_cnt, st);
        end
        idle(2);
        check(exp_cnt == CMAX, "R10 sat exp", exp_cnt, CMAX);
        check(stall_count == CMAX, "R10 sat", int'(stall_count), CMAX);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule